// File: doc/BRIEF.md
# Multiplexed Configuration Output Selector

This block drives six open-drain configuration lines from one of five 6-bit sources. Four of the sources are stored configuration words, which the storage block supplies as steady levels. The fifth is a set of six external input pins. Commands from a serial-bus front end choose the source. One command hands the choice to an external select pin, which then picks between the external pins and stored word 0.

The front end gives one strobe for the command byte of a write transaction and another for each data byte that follows it. It also pulses a strobe when the transaction ends. The block acknowledges valid selection commands and refuses data bytes that follow one.

The readback gives the current selection code. The outputs come straight from flops, so a source change cannot produce a glitch. The select pin and the external pins each pass through a two-flop synchroniser.

The control FSM has two states. ST_IDLE waits for a command. ST_REJECT is entered after a valid selection command, and while in it any data byte is refused. The transitions are:
- ST_IDLE to ST_REJECT on a valid command.
- ST_REJECT to ST_IDLE on a transaction end, or on a new command that is invalid.
- ST_REJECT stays in ST_REJECT on a data byte or on another valid command.
- ST_IDLE stays in ST_IDLE on an invalid command or on a data byte.

Top module: `cfg_out_sel`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, the selection readback is 5 (pin-controlled) and all six drive outputs are 1 (released).
- R2: A command strobe sets the selection readback as follows: byte 0xF8 gives 0 (word 0), 0xFC gives 1, 0xF9 gives 2, 0xFD gives 3, 0xFA or 0xFE gives 4 (external pins), and 0xFB gives 5 (pin-controlled).
- R3: Any other command byte is invalid, including 0xFF and any byte whose bits 7:3 are not all 1. An invalid command leaves the selection unchanged and is not acknowledged.
- R4: `ack_o` pulses high for one cycle, in the cycle after a valid command strobe, and at no other time.
- R5: A data strobe that arrives after a valid command and before the transaction end gives a one-cycle `nack_o` pulse and changes nothing. A data strobe outside that window gives no `nack_o` pulse.
- R6: In pin-controlled mode, a synchronised select pin of 1 chooses word 0 and a select pin of 0 chooses the external pins.
- R7: `drive_n_o` equals the selected 6-bit source value, bit for bit. A 0 pulls the line low and a 1 releases it. Word k sits at `nv_regs_i[6k+5:6k]`.
- R8: The selection readback changes at the clock edge that samples the command strobe. `drive_n_o` follows at the next edge, and it is only ever driven from a flop.
- R9: A change on the external pins reaches `drive_n_o` at the third clock edge after it is applied, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_stb_i | input | 1 | Command byte strobe |
| cmd_byte_i | input | 8 | Command byte |
| dat_stb_i | input | 1 | Data byte strobe within a transaction |
| txn_end_i | input | 1 | Transaction end strobe |
| nv_regs_i | input | 24 | Four stored 6-bit words, packed |
| ext_pins_i | input | 6 | External input pins (asynchronous) |
| ext_sel_i | input | 1 | External select pin (asynchronous) |
| drive_n_o | output | 6 | Open-drain drive levels, 0 pulls low |
| sel_state_o | output | 3 | Current selection code |
| ack_o | output | 1 | Valid command accepted |
| nack_o | output | 1 | Data byte refused |

## Verification
The assertions check on every cycle the reset values. They also check that every `ack_o` and `nack_o` pulse has a cause, that the two never occur together, and that an invalid command leaves the selection alone. They check as well that word 0 reaches the outputs one edge after its selection. Only the bench scenarios show the rest: the full command decode, the select-pin choice in pin-controlled mode, the three-edge synchroniser latency, and the timing split between the readback and the outputs.

// File: rtl/cfg_out_sel_pkg.sv
package cfg_out_sel_pkg;
    localparam int NWORDS = 4;

    typedef enum logic [2:0] {
        SRC_W0   = 3'd0,
        SRC_W1   = 3'd1,
        SRC_W2   = 3'd2,
        SRC_W3   = 3'd3,
        SRC_PINS = 3'd4,
        SRC_AUTO = 3'd5
    } src_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REJECT = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/cfg_out_sel_sync.sv
module cfg_out_sel_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_out_sel_decode.sv
module cfg_out_sel_decode
    import cfg_out_sel_pkg::*;
(
    input  logic [7:0] byte_i,
    output logic       valid_o,
    output src_e       src_o
);
    localparam logic [4:0] PREFIX = 5'b11111;

    always_comb begin
        valid_o = 1'b0;
        src_o   = SRC_AUTO;
        if (byte_i[7:3] == PREFIX) begin
            valid_o = 1'b1;
            unique case (byte_i[2:0])
                3'b000: src_o = SRC_W0;
                3'b100: src_o = SRC_W1;
                3'b001: src_o = SRC_W2;
                3'b101: src_o = SRC_W3;
                3'b010,
                3'b110: src_o = SRC_PINS;
                3'b011: src_o = SRC_AUTO;
                default: valid_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cfg_out_sel_fsm.sv
module cfg_out_sel_fsm
    import cfg_out_sel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_stb_i,
    input  logic cmd_ok_i,
    input  src_e cmd_src_i,
    input  logic dat_stb_i,
    input  logic txn_end_i,
    output src_e sel_o,
    output logic ack_o,
    output logic nack_o
);
    ctl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_stb_i && cmd_ok_i) state_d = ST_REJECT;
            end
            ST_REJECT: begin
                if (txn_end_i)                     state_d = ST_IDLE;
                else if (cmd_stb_i && !cmd_ok_i)   state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_o  <= SRC_AUTO;
            ack_o  <= 1'b0;
            nack_o <= 1'b0;
        end else begin
            ack_o  <= cmd_stb_i && cmd_ok_i;
            nack_o <= dat_stb_i && !cmd_stb_i && (state_q == ST_REJECT);
            if (cmd_stb_i && cmd_ok_i) sel_o <= cmd_src_i;
        end
    end
endmodule

// File: rtl/cfg_out_sel.sv
module cfg_out_sel
    import cfg_out_sel_pkg::*;
#(
    parameter int DW          = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_stb_i,
    input  logic [7:0]           cmd_byte_i,
    input  logic                 dat_stb_i,
    input  logic                 txn_end_i,
    input  logic [NWORDS*DW-1:0] nv_regs_i,
    input  logic [DW-1:0]        ext_pins_i,
    input  logic                 ext_sel_i,
    output logic [DW-1:0]        drive_n_o,
    output logic [2:0]           sel_state_o,
    output logic                 ack_o,
    output logic                 nack_o
);
    localparam int SW = DW + 1;

    logic [DW-1:0] word [NWORDS];
    logic [SW-1:0] sync_out;
    logic [DW-1:0] pins_s;
    logic          sel_s;
    logic          cmd_ok;
    src_e          cmd_src;
    src_e          sel;
    logic [DW-1:0] out_d, out_q;

    genvar k;
    generate
        for (k = 0; k < NWORDS; k++) begin : g_word
            assign word[k] = nv_regs_i[k*DW +: DW];
        end
    endgenerate

    cfg_out_sel_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ext_sel_i, ext_pins_i}),
        .sync_o  (sync_out)
    );
    assign pins_s = sync_out[DW-1:0];
    assign sel_s  = sync_out[DW];

    cfg_out_sel_decode u_dec (
        .byte_i  (cmd_byte_i),
        .valid_o (cmd_ok),
        .src_o   (cmd_src)
    );

    cfg_out_sel_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_stb_i (cmd_stb_i),
        .cmd_ok_i  (cmd_ok),
        .cmd_src_i (cmd_src),
        .dat_stb_i (dat_stb_i),
        .txn_end_i (txn_end_i),
        .sel_o     (sel),
        .ack_o     (ack_o),
        .nack_o    (nack_o)
    );

    always_comb begin
        unique case (sel)
            SRC_W0:   out_d = word[0];
            SRC_W1:   out_d = word[1];
            SRC_W2:   out_d = word[2];
            SRC_W3:   out_d = word[3];
            SRC_PINS: out_d = pins_s;
            default:  out_d = sel_s ? word[0] : pins_s;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '1;
        else        out_q <= out_d;
    end

    assign drive_n_o   = out_q;
    assign sel_state_o = sel;
endmodule

// File: rtl/cfg_out_sel_chk.sv
module cfg_out_sel_chk #(
    parameter int DW = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_stb_i,
    input logic [7:0]        cmd_byte_i,
    input logic              dat_stb_i,
    input logic              txn_end_i,
    input logic [4*DW-1:0]   nv_regs_i,
    input logic [DW-1:0]     ext_pins_i,
    input logic              ext_sel_i,
    input logic [DW-1:0]     drive_n_o,
    input logic [2:0]        sel_state_o,
    input logic              ack_o,
    input logic              nack_o
);
    logic bad_cmd;
    assign bad_cmd = (cmd_byte_i[7:3] != 5'h1F) || (cmd_byte_i[2:0] == 3'b111);

    // R1
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sel_state_o == 3'd5 && drive_n_o == '1));

    // R3
    a_r3_invalid_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb_i && bad_cmd) |=> ($stable(sel_state_o) && !ack_o));

    // R4
    a_r4_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(cmd_stb_i));

    // R5
    a_r5_nack_cause: assert property (@(posedge clk) disable iff (!rst_n)
        nack_o |-> $past(dat_stb_i));

    // R5
    a_r5_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_o && nack_o));

    // R7
    a_r7_word0_out: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_state_o == 3'd0) |=> (drive_n_o == $past(nv_regs_i[DW-1:0])));
endmodule

bind cfg_out_sel cfg_out_sel_chk #(.DW(DW)) u_chk (.*);

// File: tb/cfg_out_sel_tb.sv
module cfg_out_sel_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NV = 12;
    // {cmd[24:17], sel[16], pins[15:10], exp_out[9:4], exp_state[3:1], exp_ack[0]}
    localparam logic [24:0] VEC [NV] = '{
        {8'hF8, 1'b0, 6'h00, 6'h15, 3'd0, 1'b1},
        {8'hFC, 1'b0, 6'h00, 6'h2A, 3'd1, 1'b1},
        {8'hF9, 1'b0, 6'h00, 6'h33, 3'd2, 1'b1},
        {8'hFD, 1'b0, 6'h00, 6'h0C, 3'd3, 1'b1},
        {8'hFA, 1'b0, 6'h3C, 6'h3C, 3'd4, 1'b1},
        {8'hFE, 1'b0, 6'h01, 6'h01, 3'd4, 1'b1},
        {8'hFB, 1'b0, 6'h22, 6'h22, 3'd5, 1'b1},
        {8'hFB, 1'b1, 6'h22, 6'h15, 3'd5, 1'b1},
        {8'hFF, 1'b0, 6'h07, 6'h07, 3'd5, 1'b0},
        {8'h00, 1'b1, 6'h07, 6'h15, 3'd5, 1'b0},
        {8'hF8, 1'b1, 6'h07, 6'h15, 3'd0, 1'b1},
        {8'hF7, 1'b0, 6'h07, 6'h15, 3'd0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_stb_i = 1'b0;
    logic [7:0]  cmd_byte_i = 8'h00;
    logic        dat_stb_i = 1'b0;
    logic        txn_end_i = 1'b0;
    logic [23:0] nv_regs_i = {6'h0C, 6'h33, 6'h2A, 6'h15};
    logic [5:0]  ext_pins_i = 6'h00;
    logic        ext_sel_i = 1'b0;
    logic [5:0]  drive_n_o;
    logic [2:0]  sel_state_o;
    logic        ack_o, nack_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_out_sel u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_stb_i(cmd_stb_i), .cmd_byte_i(cmd_byte_i),
        .dat_stb_i(dat_stb_i), .txn_end_i(txn_end_i), .nv_regs_i(nv_regs_i),
        .ext_pins_i(ext_pins_i), .ext_sel_i(ext_sel_i), .drive_n_o(drive_n_o),
        .sel_state_o(sel_state_o), .ack_o(ack_o), .nack_o(nack_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [7:0] b, input bit end_txn);
        @(negedge clk);
        cmd_byte_i = b;
        cmd_stb_i  = 1'b1;
        @(negedge clk);
        cmd_stb_i  = 1'b0;
        if (end_txn) begin
            txn_end_i = 1'b1;
            @(negedge clk);
            txn_end_i = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sel_state_o == 3'd5, "R1 state", sel_state_o, 5);
        chk(drive_n_o == 6'h3F, "R1 outputs", drive_n_o, 6'h3F);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            ext_sel_i  = VEC[i][16];
            ext_pins_i = VEC[i][15:10];
            @(negedge clk);
            cmd_byte_i = VEC[i][24:17];
            cmd_stb_i  = 1'b1;
            @(negedge clk);
            cmd_stb_i  = 1'b0;
            chk(ack_o == VEC[i][0], "R4 ack", ack_o, VEC[i][0]);
            txn_end_i = 1'b1;
            @(negedge clk);
            txn_end_i = 1'b0;
            repeat (4) @(negedge clk);
            chk(sel_state_o == VEC[i][3:1], "R2/R3 state", sel_state_o, VEC[i][3:1]);
            chk(drive_n_o == VEC[i][9:4], "R6/R7 output", drive_n_o, VEC[i][9:4]);
        end

        // R8: readback at the strobe edge, outputs one edge later (now word 0 = 15)
        @(negedge clk);
        cmd_byte_i = 8'hFC;
        cmd_stb_i  = 1'b1;
        @(negedge clk);
        cmd_stb_i = 1'b0;
        chk(sel_state_o == 3'd1, "R8 readback", sel_state_o, 1);
        chk(drive_n_o == 6'h15, "R8 output held", drive_n_o, 6'h15);
        @(negedge clk);
        chk(drive_n_o == 6'h2A, "R8 output next edge", drive_n_o, 6'h2A);
        txn_end_i = 1'b1;
        @(negedge clk);
        txn_end_i = 1'b0;

        // R9: pin path latency
        send_cmd(8'hFA, 1'b1);
        repeat (4) @(negedge clk);
        chk(drive_n_o == 6'h07, "R9 before", drive_n_o, 6'h07);
        ext_pins_i = 6'h30;
        repeat (2) @(negedge clk);
        chk(drive_n_o == 6'h07, "R9 two edges", drive_n_o, 6'h07);
        @(negedge clk);
        chk(drive_n_o == 6'h30, "R9 three edges", drive_n_o, 6'h30);

        // R5: data byte after a mux command is refused
        send_cmd(8'hF8, 1'b0);
        chk(ack_o == 1'b1, "R4 ack no end", ack_o, 1);
        dat_stb_i = 1'b1;
        @(negedge clk);
        dat_stb_i = 1'b0;
        chk(nack_o == 1'b1, "R5 nack", nack_o, 1);
        chk(sel_state_o == 3'd0, "R5 state kept", sel_state_o, 0);
        @(negedge clk);
        chk(nack_o == 1'b0, "R5 one cycle", nack_o, 0);
        chk(drive_n_o == 6'h15, "R5 output kept", drive_n_o, 6'h15);
        txn_end_i = 1'b1;
        @(negedge clk);
        txn_end_i = 1'b0;
        dat_stb_i = 1'b1;
        @(negedge clk);
        dat_stb_i = 1'b0;
        chk(nack_o == 1'b0, "R5 outside window", nack_o, 0);

        // R3: invalid command after a valid one leaves selection alone
        send_cmd(8'hFF, 1'b1);
        chk(ack_o == 1'b0, "R3 no ack", ack_o, 0);
        chk(sel_state_o == 3'd0, "R3 kept", sel_state_o, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule